// File: doc/BRIEF.md
# Clock Divider Reconfiguration Sequencer

This block reprograms a clock synthesizer. A caller presents three divider settings: the input (reference) divider, the feedback multiplier and the output divider. The caller then pulses a start strobe. The sequencer splits each divider into a high-time count, a low-time count, an odd-divide edge bit and a divide-by-one bypass bit. It picks a loop-filter word and a lock word from tables indexed by the multiplier minus one. It then drives ten register updates, always in the same order, over a 16-bit register port.

Every update is a masked merge. Unless the mask is all ones, the sequencer first reads the target register. It keeps the bits outside the mask and replaces the bits inside it. Each port transfer is held until the port reports ready. A triple that contains a zero is refused at once and causes no port traffic. A single done pulse closes every request, with an error flag beside it when the triple was refused.

Top module: `clkseq`

## Requirements
- R1: A divider N is split as high = floor(N/2), low = N - high, edge = N mod 2, and no-count = 1 only for N = 1. The split words are computed in 16 bits as (high<<6)|low; the edge/bypass word is (edge<<7)|(nocount<<6).
- R2: Each update leaves the register equal to (old AND NOT mask) OR (value AND mask). Register bits outside the mask are never changed.
- R3: Every write whose mask is not 0xFFFF comes directly after a read of the same address. The port address does not change between that read and the write.
- R4: The output divider writes address 0x08 with (high<<6)|low under mask 0xEFFF. It writes address 0x09 with (edge<<7)|(nocount<<6) under mask 0x03FF.
- R5: The input divider writes address 0x16 with (edge<<13)|(nocount<<12)|(high<<6)|low under mask 0x3FFF.
- R6: The feedback multiplier writes 0x14 and 0x15 with the same word formats and masks that R4 uses.
- R7: Let k = M-1. The lock word L comes from a 36-entry table; for k of 36 or more it is 0x1F1F00FA. Address 0x18 gets L[9:0] under mask 0x03FF. Address 0x19 gets (L[20:16]<<10)|0x001 under mask 0x7FFF. Address 0x1A gets (L[28:24]<<10)|0x3E9 under mask 0x7FFF.
- R8: The filter word F depends on k as follows. k=0: 0x01001990. k=1: 0x01001190. k=2: 0x01009890. k=3: 0x01001890. k=4: 0x01008890. 5..8: 0x01009090. 9..11: 0x01000890. 12: 0x08009090. 13..22: 0x01001090. 23..36: 0x01008090. 37..46: 0x08001090. Above 46: 0x08008090. Address 0x4E gets F[31:16] and address 0x4F gets F[15:0], both under mask 0x9900.
- R9: The ten updates go to 0x08, 0x09, 0x16, 0x14, 0x15, 0x18, 0x19, 0x1A, 0x4E, 0x4F, in that order. Each is one read followed by one write.
- R10: A start with D, M or DOUT equal to zero raises done and err together one cycle later and makes no port request.
- R11: A port request holds its address, direction and write data unchanged until a cycle in which ready is high.
- R12: done is high for exactly one cycle. After a valid run it comes in the cycle after the last write is accepted, with err low. err is never high without done.
- R13: Out of reset, and whenever busy is low, there is no port request and done is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reprogramming run (taken only while busy is low) |
| divIn | input | DIV_W | Input divider D |
| mulFb | input | MUL_W | Feedback multiplier M |
| divOut | input | DIV_W | Output divider DOUT |
| busy | output | 1 | A run or a refusal is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Set together with done when the triple was refused |
| portReq | output | 1 | Register port transfer request |
| portWe | output | 1 | 1 = write, 0 = read |
| portAddr | output | ADDR_W | Register address |
| portWdata | output | 16 | Merged write data |
| portRdata | input | 16 | Read data, valid with portReady on a read |
| portReady | input | 1 | Transfer accepted this cycle |

## Verification
A refused triple shows done and err one clock edge after start is sampled, so the bench checks them at the next falling edge and checks that done has dropped one edge later. A valid run takes as many cycles as the random ready stalls allow. The bench therefore waits for done at falling edges, then compares the transfer log and the register model of the port, which by that point hold the whole run. Expected register contents come from a seeded snapshot of each register's old value and a bench-side model of the encodings and tables.

// File: rtl/clkseq_pkg.sv
`timescale 1ns/1ps
package clkseq_pkg;

  localparam int DATA_W    = 16;
  localparam int NUM_STEPS = 10;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch triple, rewind step
    logic capture;  // keep read data for merge
    logic stepInc;  // advance to next update
  } dpCtl_t;

  typedef struct packed {
    logic [DATA_W-1:0] hiTime;
    logic [DATA_W-1:0] loTime;
    logic              edgeBit;
    logic              noCount;
  } divFields_t;

  function automatic divFields_t splitDiv(input logic [DATA_W-1:0] n);
    divFields_t f;
    f.hiTime  = n >> 1;
    f.loTime  = n - f.hiTime;
    f.edgeBit = n[0];
    f.noCount = (n == DATA_W'(1));
    return f;
  endfunction

  function automatic logic [DATA_W-1:0] countWord(input divFields_t f);
    return (f.hiTime << 6) | f.loTime;
  endfunction

  function automatic logic [DATA_W-1:0] flagWord(input divFields_t f);
    return {8'b0, f.edgeBit, f.noCount, 6'b0};
  endfunction

  // sequence of target addresses; order is part of the behaviour
  function automatic logic [7:0] stepAddr(input int s);
    case (s)
      0: return 8'h08;
      1: return 8'h09;
      2: return 8'h16;
      3: return 8'h14;
      4: return 8'h15;
      5: return 8'h18;
      6: return 8'h19;
      7: return 8'h1A;
      8: return 8'h4E;
      9: return 8'h4F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] stepMask(input int s);
    case (s)
      0, 3:    return 16'hEFFF;
      1, 4:    return 16'h03FF;
      2:       return 16'h3FFF;
      5:       return 16'h03FF;
      6, 7:    return 16'h7FFF;
      8, 9:    return 16'h9900;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [31:0] filterFor(input int k);
    case (k) inside
      0:        return 32'h01001990;
      1:        return 32'h01001190;
      2:        return 32'h01009890;
      3:        return 32'h01001890;
      4:        return 32'h01008890;
      [5:8]:    return 32'h01009090;
      [9:11]:   return 32'h01000890;
      12:       return 32'h08009090;
      [13:22]:  return 32'h01001090;
      [23:36]:  return 32'h01008090;
      [37:46]:  return 32'h08001090;
      default:  return 32'h08008090;
    endcase
  endfunction

  function automatic logic [31:0] mkLock(input logic [4:0] cnt, input logic [9:0] refCnt);
    return {3'b0, cnt, 3'b0, cnt, 6'b0, refCnt};
  endfunction

  function automatic logic [31:0] lockFor(input int k);
    case (k)
      0, 1:   return mkLock(5'd6,  10'h3E8);
      2:      return mkLock(5'd8,  10'h3E8);
      3:      return mkLock(5'd11, 10'h3E8);
      4:      return mkLock(5'd14, 10'h3E8);
      5:      return mkLock(5'd17, 10'h3E8);
      6:      return mkLock(5'd19, 10'h3E8);
      7:      return mkLock(5'd22, 10'h3E8);
      8:      return mkLock(5'd25, 10'h3E8);
      9:      return mkLock(5'd28, 10'h3E8);
      10:     return mkLock(5'd31, 10'h384);
      11:     return mkLock(5'd31, 10'h339);
      12:     return mkLock(5'd31, 10'h2EE);
      13:     return mkLock(5'd31, 10'h2BC);
      14:     return mkLock(5'd31, 10'h28A);
      15:     return mkLock(5'd31, 10'h271);
      16:     return mkLock(5'd31, 10'h23F);
      17:     return mkLock(5'd31, 10'h226);
      18:     return mkLock(5'd31, 10'h20D);
      19:     return mkLock(5'd31, 10'h1F4);
      20:     return mkLock(5'd31, 10'h1DB);
      21:     return mkLock(5'd31, 10'h1C2);
      22:     return mkLock(5'd31, 10'h1A9);
      23, 24: return mkLock(5'd31, 10'h190);
      25:     return mkLock(5'd31, 10'h177);
      26, 27: return mkLock(5'd31, 10'h15E);
      28, 29: return mkLock(5'd31, 10'h145);
      30, 31, 32: return mkLock(5'd31, 10'h12C);
      33, 34, 35: return mkLock(5'd31, 10'h113);
      default: return mkLock(5'd31, 10'h0FA);
    endcase
  endfunction

endpackage

// File: rtl/clkseq_dp.sv
`timescale 1ns/1ps
module clkseq_dp
  import clkseq_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int MUL_W  = 7,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DIV_W-1:0]  divIn,
  input  logic [MUL_W-1:0]  mulFb,
  input  logic [DIV_W-1:0]  divOut,
  input  logic [DATA_W-1:0] portRdata,
  output logic              tripleBad,
  output logic              lastStep,
  output logic              firstNeedRead,
  output logic              nextNeedRead,
  output logic [ADDR_W-1:0] portAddr,
  output logic [DATA_W-1:0] portWdata
);

  localparam int STEP_W = $clog2(NUM_STEPS + 1);

  logic [DIV_W-1:0]  dReg, oReg;
  logic [MUL_W-1:0]  mReg;
  logic [STEP_W-1:0] stepIdx;
  logic [DATA_W-1:0] oldVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dReg    <= '0;
      oReg    <= '0;
      mReg    <= '0;
      stepIdx <= '0;
      oldVal  <= '0;
    end else begin
      if (ctl.load) begin
        dReg    <= divIn;
        oReg    <= divOut;
        mReg    <= mulFb;
        stepIdx <= '0;
      end else if (ctl.stepInc) begin
        stepIdx <= stepIdx + STEP_W'(1);
      end
      if (ctl.capture) oldVal <= portRdata;
    end
  end

  divFields_t dF, mF, oF;
  logic [31:0] lockWord, filtWord;
  logic [DATA_W-1:0] newVal, curMask;
  logic curNeedRead;
  int mIdx;

  always_comb begin
    dF       = splitDiv(DATA_W'(dReg));
    mF       = splitDiv(DATA_W'(mReg));
    oF       = splitDiv(DATA_W'(oReg));
    mIdx     = int'(mReg) - 1;
    lockWord = lockFor(mIdx);
    filtWord = filterFor(mIdx);
    case (int'(stepIdx))
      0:       newVal = countWord(oF);
      1:       newVal = flagWord(oF);
      2:       newVal = {2'b0, dF.edgeBit, dF.noCount, 12'b0} | countWord(dF);
      3:       newVal = countWord(mF);
      4:       newVal = flagWord(mF);
      5:       newVal = {6'b0, lockWord[9:0]};
      6:       newVal = {1'b0, lockWord[20:16], 10'h001};
      7:       newVal = {1'b0, lockWord[28:24], 10'h3E9};
      8:       newVal = filtWord[31:16];
      9:       newVal = filtWord[15:0];
      default: newVal = '0;
    endcase
    curMask     = stepMask(int'(stepIdx));
    curNeedRead = (curMask != 16'hFFFF);
    portWdata   = curNeedRead ? ((oldVal & ~curMask) | (newVal & curMask))
                              : (newVal & curMask);
    portAddr    = ADDR_W'(stepAddr(int'(stepIdx)));
  end

  assign tripleBad     = (divIn == '0) || (mulFb == '0) || (divOut == '0);
  assign lastStep      = (stepIdx == STEP_W'(NUM_STEPS - 1));
  assign firstNeedRead = (stepMask(0) != 16'hFFFF);
  assign nextNeedRead  = (stepMask(int'(stepIdx) + 1) != 16'hFFFF);

endmodule

// File: rtl/clkseq_ctrl.sv
`timescale 1ns/1ps
module clkseq_ctrl
  import clkseq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   tripleBad,
  input  logic   lastStep,
  input  logic   firstNeedRead,
  input  logic   nextNeedRead,
  input  logic   portReady,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   done,
  output logic   err,
  output logic   portReq,
  output logic   portWe
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WRITE, ST_FINISH, ST_REFUSE
  } seqState_t;

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    portReq     = 1'b0;
    portWe      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (tripleBad) begin
            stateNext = ST_REFUSE;
          end else begin
            ctl.load  = 1'b1;
            stateNext = firstNeedRead ? ST_READ : ST_WRITE;
          end
        end
      end
      ST_READ: begin
        portReq = 1'b1;
        if (portReady) begin
          ctl.capture = 1'b1;
          stateNext   = ST_WRITE;
        end
      end
      ST_WRITE: begin
        portReq = 1'b1;
        portWe  = 1'b1;
        if (portReady) begin
          if (lastStep) begin
            stateNext = ST_FINISH;
          end else begin
            ctl.stepInc = 1'b1;
            stateNext   = nextNeedRead ? ST_READ : ST_WRITE;
          end
        end
      end
      ST_FINISH: stateNext = ST_IDLE;
      ST_REFUSE: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH) || (state == ST_REFUSE);
  assign err  = (state == ST_REFUSE);

endmodule

// File: rtl/clkseq.sv
`timescale 1ns/1ps
module clkseq
  import clkseq_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int MUL_W  = 7,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DIV_W-1:0]  divIn,
  input  logic [MUL_W-1:0]  mulFb,
  input  logic [DIV_W-1:0]  divOut,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              portReq,
  output logic              portWe,
  output logic [ADDR_W-1:0] portAddr,
  output logic [15:0]       portWdata,
  input  logic [15:0]       portRdata,
  input  logic              portReady
);

  dpCtl_t ctl;
  logic tripleBad, lastStep, firstNeedRead, nextNeedRead;

  clkseq_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .tripleBad    (tripleBad),
    .lastStep     (lastStep),
    .firstNeedRead(firstNeedRead),
    .nextNeedRead (nextNeedRead),
    .portReady    (portReady),
    .ctl          (ctl),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .portReq      (portReq),
    .portWe       (portWe)
  );

  clkseq_dp #(.DIV_W(DIV_W), .MUL_W(MUL_W), .ADDR_W(ADDR_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .divIn        (divIn),
    .mulFb        (mulFb),
    .divOut       (divOut),
    .portRdata    (portRdata),
    .tripleBad    (tripleBad),
    .lastStep     (lastStep),
    .firstNeedRead(firstNeedRead),
    .nextNeedRead (nextNeedRead),
    .portAddr     (portAddr),
    .portWdata    (portWdata)
  );

endmodule

// File: rtl/clkseq_chk.sv
`timescale 1ns/1ps
module clkseq_chk #(
  parameter int DIV_W  = 8,
  parameter int MUL_W  = 7,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [DIV_W-1:0]  divIn,
  input logic [MUL_W-1:0]  mulFb,
  input logic [DIV_W-1:0]  divOut,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              portReq,
  input logic              portWe,
  input logic [ADDR_W-1:0] portAddr,
  input logic [15:0]       portWdata,
  input logic              portReady
);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (portReq && !portReady) |=> (portReq && $stable(portAddr) && $stable(portWe) && $stable(portWdata)));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  // R10
  refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (divIn == '0 || mulFb == '0 || divOut == '0)) |=> (done && err && !portReq));

  // R3
  rmw_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (portReq && !portWe && portReady) |=> (portReq && portWe && $stable(portAddr)));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!portReq && !done));

endmodule

bind clkseq clkseq_chk #(.DIV_W(DIV_W), .MUL_W(MUL_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .divIn(divIn), .mulFb(mulFb),
  .divOut(divOut), .busy(busy), .done(done), .err(err), .portReq(portReq),
  .portWe(portWe), .portAddr(portAddr), .portWdata(portWdata), .portReady(portReady)
);

// File: tb/clkseq_tb_top.sv
`timescale 1ns/1ps
module clkseq_tb_top;

  localparam int DIV_W = 8, MUL_W = 7, ADDR_W = 7;
  localparam int LOG_N = 4096;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [DIV_W-1:0] divIn = '0, divOut = '0;
  logic [MUL_W-1:0] mulFb = '0;
  logic busy, done, err, portReq, portWe;
  logic [ADDR_W-1:0] portAddr;
  logic [15:0] portWdata, portRdata;
  logic portReady = 1'b0;

  int checks = 0, errors = 0, cycles = 0;
  int txCount = 0;
  logic [ADDR_W-1:0] txAddr [LOG_N];
  logic              txWe   [LOG_N];
  logic [15:0] regs [128];
  logic seedLoad = 1'b0;
  int unsigned runSeed = 0;

  always #2.5 clk = ~clk;

  clkseq #(.DIV_W(DIV_W), .MUL_W(MUL_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .divIn(divIn), .mulFb(mulFb),
    .divOut(divOut), .busy(busy), .done(done), .err(err), .portReq(portReq),
    .portWe(portWe), .portAddr(portAddr), .portWdata(portWdata),
    .portRdata(portRdata), .portReady(portReady)
  );

  function automatic logic [15:0] seedVal(int unsigned s, int a);
    int unsigned v;
    v = (s * 32'h9E37) ^ (a * 32'h7F4A) ^ (s >> 3) ^ (a << 9);
    return v[15:0];
  endfunction

  // port model: register file with random ready
  assign portRdata = regs[portAddr];
  always @(negedge clk) portReady <= ($urandom_range(0, 3) != 0);
  always @(posedge clk) begin
    if (seedLoad) begin
      for (int a = 0; a < 128; a++) regs[a] <= seedVal(runSeed, a);
    end else if (portReq && portReady) begin
      txAddr[txCount % LOG_N] <= portAddr;
      txWe[txCount % LOG_N]   <= portWe;
      txCount <= txCount + 1;
      if (portWe) regs[portAddr] <= portWdata;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // bench-side model of requirement values
  function automatic int cntW(int n);  // R1
    return ((n / 2) << 6) | (n - n / 2);
  endfunction
  function automatic int flgW(int n);  // R1
    return ((n % 2) << 7) | ((n == 1 ? 1 : 0) << 6);
  endfunction
  function automatic int refCnt(int k);  // R7
    int tail [26] = '{'h384,'h339,'h2ee,'h2bc,'h28a,'h271,'h23f,'h226,'h20d,'h1f4,
                      'h1db,'h1c2,'h1a9,'h190,'h190,'h177,'h15e,'h15e,'h145,'h145,
                      'h12c,'h12c,'h12c,'h113,'h113,'h113};
    if (k >= 36) return 'h0fa;
    if (k < 10) return 'h3e8;
    return tail[k - 10];
  endfunction
  function automatic int lockCnt(int k);  // R7
    int head [10] = '{6, 6, 8, 11, 14, 17, 19, 22, 25, 28};
    return (k < 10) ? head[k] : 31;
  endfunction
  function automatic int filt(int k);  // R8
    if (k == 0) return 'h01001990;
    if (k == 1) return 'h01001190;
    if (k == 2) return 'h01009890;
    if (k == 3) return 'h01001890;
    if (k == 4) return 'h01008890;
    if (k <= 8) return 'h01009090;
    if (k <= 11) return 'h01000890;
    if (k == 12) return 'h08009090;
    if (k <= 22) return 'h01001090;
    if (k <= 36) return 'h01008090;
    if (k <= 46) return 'h08001090;
    return 'h08008090;
  endfunction
  function automatic int expAddr(int s);  // R9
    int t [10] = '{'h08, 'h09, 'h16, 'h14, 'h15, 'h18, 'h19, 'h1a, 'h4e, 'h4f};
    return t[s];
  endfunction
  function automatic int expMask(int s);  // R4 R5 R6 R7 R8
    int t [10] = '{'hefff, 'h03ff, 'h3fff, 'hefff, 'h03ff, 'h03ff, 'h7fff, 'h7fff, 'h9900, 'h9900};
    return t[s];
  endfunction
  function automatic int expVal(int s, int d, int m, int o);
    int k = m - 1;
    case (s)
      0: return cntW(o);
      1: return flgW(o);
      2: return ((d % 2) << 13) | ((d == 1 ? 1 : 0) << 12) | cntW(d);
      3: return cntW(m);
      4: return flgW(m);
      5: return refCnt(k);
      6: return (lockCnt(k) << 10) | 1;
      7: return (lockCnt(k) << 10) | 'h3e9;
      8: return (filt(k) >> 16) & 'hffff;
      default: return filt(k) & 'hffff;
    endcase
  endfunction
  function automatic string stepReq(int s);
    case (s)
      0, 1: return "R4";
      2: return "R5";
      3, 4: return "R6";
      5, 6, 7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic runCase(input int d, input int m, input int o);
    int base, n;
    @(negedge clk);
    runSeed  = $urandom;
    seedLoad = 1'b1;
    @(negedge clk);
    seedLoad = 1'b0;
    base   = txCount;
    divIn  = DIV_W'(d);
    mulFb  = MUL_W'(m);
    divOut = DIV_W'(o);
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (d == 0 || m == 0 || o == 0) begin
      // R10: refusal one cycle after start, no traffic
      check(done && err && !portReq, "R10", "refuse flags", {29'b0, done, err, portReq}, 32'h6);
      @(negedge clk);
      check(!done, "R12", "done pulse width", {31'b0, done}, 0);
      check(txCount == base, "R10", "port transfers on refusal", txCount - base, 0);
      return;
    end
    while (!done) @(negedge clk);
    check(!err, "R12", "err on valid run", {31'b0, err}, 0);
    @(negedge clk);
    check(!done, "R12", "done pulse width", {31'b0, done}, 0);
    n = txCount - base;
    check(n == 20, "R9", "transfer count", n, 20);
    if (n != 20) return;
    for (int s = 0; s < 10; s++) begin
      logic [15:0] oldV, expV;
      int ra = base + 2 * s, wa = base + 2 * s + 1;
      // R3 / R9: read then write of the same expected address
      check(!txWe[ra % LOG_N] && txWe[wa % LOG_N] &&
            int'(txAddr[ra % LOG_N]) == expAddr(s) && int'(txAddr[wa % LOG_N]) == expAddr(s),
            "R3", $sformatf("R9 step %0d addr/order", s),
            {txAddr[ra % LOG_N], txAddr[wa % LOG_N]}, {7'(expAddr(s)), 7'(expAddr(s))});
      oldV = seedVal(runSeed, expAddr(s));
      expV = (oldV & ~16'(expMask(s))) | (16'(expVal(s, d, m, o)) & 16'(expMask(s)));
      // R1 / R2 plus the step's own requirement
      check(regs[expAddr(s)] == expV, stepReq(s),
            $sformatf("R1 R2 reg 0x%0h (d=%0d m=%0d o=%0d)", expAddr(s), d, m, o),
            regs[expAddr(s)], expV);
    end
  endtask

  initial begin
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    // R13: reset state
    check(!busy && !done && !portReq && !err, "R13", "reset outputs",
          {28'b0, busy, done, portReq, err}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !portReq, "R13", "idle after reset", {30'b0, busy, portReq}, 0);
    // directed corners
    runCase(1, 1, 1);
    runCase(80, 64, 128);
    runCase(3, 47, 2);
    runCase(7, 36, 5);
    runCase(4, 37, 9);
    runCase(2, 13, 6);
    runCase(9, 6, 1);
    runCase(5, 13, 64);
    runCase(0, 4, 4);
    runCase(4, 0, 4);
    runCase(4, 4, 0);
    // random triples
    for (int i = 0; i < 24; i++)
      runCase($urandom_range(1, 80), $urandom_range(1, 64), $urandom_range(1, 128));
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule